// File: doc/BRIEF.md
# Variable-Format DMA Descriptor Walker

This block locates and reads buffer descriptors in a DMA ring whose entry size is picked at run time, and writes captured timestamps back into them. Two mode bits decide the layout: wide (64-bit) buffer addressing and extended descriptors, which carry timestamps. An entry is 2, 4 or 6 words of 32 bits. The low buffer address is always in word 0 and the control word is always in word 1. With wide addressing, word 2 holds the upper address bits and word 3 is spare. With extended descriptors, the last two words of the entry hold the timestamp pair.

A fetch request with a ring index makes the walker compute the entry's byte address. It then reads the needed words over a 32-bit memory port that returns read data one cycle after the request, and presents the assembled 64-bit buffer address and the control word with a one-cycle done strobe. A stamp request with the same index input writes the two timestamp words into the entry, but only when extended descriptors are enabled for the direction of the ring being walked.

The sequencer has seven states. IDLE accepts a request. RD_LO, RD_CTL and RD_HI each issue one read. RD_END waits for the last read data. WR_TS1 and WR_TS2 each issue one write. The transitions are:
- IDLE to RD_LO on a fetch request.
- IDLE to WR_TS1 on an enabled stamp request.
- RD_LO to RD_CTL.
- RD_CTL to RD_HI when addressing is wide, otherwise RD_CTL to RD_END.
- RD_HI to RD_END.
- RD_END to IDLE.
- WR_TS1 to WR_TS2.
- WR_TS2 to IDLE.

Top module: `dscr_walker`

## Requirements
- R1: After reset, done and mem_req are low, and buf_addr and buf_ctrl are zero.
- R2: The mode bits are decoded as follows. Wide mode is dma_cfg bit 30. Extended mode is dma_cfg bit 28 for a receive ring (ring_tx=0) and dma_cfg bit 29 for a transmit ring (ring_tx=1). The entry byte address is ring_base + 8*desc_idx*k, where k is 1 with neither mode, 2 with exactly one mode and 3 with both.
- R3: A fetch issues one read per cycle in consecutive cycles, starting the cycle after fetch_req is sampled. The reads go to entry+0 and entry+4, and then to entry+8 only in wide mode. buf_ctrl takes the word read from entry+4.
- R4: buf_addr is {word at entry+8, word at entry+0} in wide mode. In narrow mode its upper 32 bits are zero.
- R5: done is high for exactly one cycle. For a fetch, it rises in the second cycle after the last read request, with buf_addr and buf_ctrl already valid.
- R6: An enabled stamp writes stamp_w1 and then stamp_w2 in two consecutive cycles. The writes go to entry+8 and entry+12 in narrow mode, or to entry+16 and entry+20 in wide mode. done is high in the cycle after the second write.
- R7: A stamp request while extended mode is off for the ring's direction makes no memory access and gives no done.
- R8: fetch_req and stamp_req are ignored while a fetch or a stamp is in progress.
- R9: If fetch_req and stamp_req arrive together while idle, the fetch is performed and the stamp is dropped.
- R10: mem_we is high only during the two stamp writes, and every mem_we cycle also has mem_req high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | AW | Byte address of ring entry 0 |
| dma_cfg | input | 32 | DMA configuration word holding the mode bits |
| ring_tx | input | 1 | 1: transmit ring, 0: receive ring |
| desc_idx | input | IDXW | Ring index for fetch or stamp |
| fetch_req | input | 1 | Start a descriptor fetch |
| stamp_req | input | 1 | Start a timestamp write-back |
| stamp_w1 | input | 32 | First timestamp word |
| stamp_w2 | input | 32 | Second timestamp word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read |
| buf_addr | output | 64 | Assembled buffer address |
| buf_ctrl | output | 32 | Descriptor control word |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench runs all four layouts on both ring directions and checks them against a word memory model.

It targets the index multiplier: a design that doubles the index in every extended layout, or never triples it, would place six-word entries at the wrong addresses. A high index with both modes on exposes any truncation in the offset arithmetic.

It also targets narrow mode, where a walker that leaves stale upper address bits in place, or reads the spare word, shows up at buf_addr and in the read count. Stamps aimed at a ring whose direction bit is clear, requests raised mid-walk and coincident fetch and stamp requests each show whether a design lets a stray write or a second walk through.

// File: rtl/dw_pkg.sv
package dw_pkg;
    localparam int CFG_WIDE_BIT   = 30;
    localparam int CFG_RX_EXT_BIT = 28;
    localparam int CFG_TX_EXT_BIT = 29;
    localparam int OFFW           = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_RD_CTL,
        ST_RD_HI,
        ST_RD_END,
        ST_WR_TS1,
        ST_WR_TS2
    } walk_state_e;

    typedef enum logic [1:0] {
        CAP_NONE,
        CAP_LO,
        CAP_CTL,
        CAP_HI
    } cap_sel_e;
endpackage

// File: rtl/dw_geom.sv
module dw_geom
    import dw_pkg::*;
#(
    parameter int AW   = 32,
    parameter int IDXW = 10
) (
    input  logic [AW-1:0]   base,
    input  logic [31:0]     cfg,
    input  logic            ring_tx,
    input  logic [IDXW-1:0] idx,
    output logic            wide,
    output logic            ext,
    output logic [AW-1:0]   desc_addr
);
    localparam int UW = IDXW + 2;

    logic [UW-1:0] idx_x;
    logic [UW-1:0] units;
    logic          cfg_unused;

    assign cfg_unused = ^cfg;
    assign wide       = cfg[CFG_WIDE_BIT];
    assign ext        = ring_tx ? cfg[CFG_TX_EXT_BIT] : cfg[CFG_RX_EXT_BIT];

    assign idx_x = {2'b00, idx};
    // one step of two words per index, plus one per enabled mode
    assign units = idx_x + (wide ? idx_x : '0) + (ext ? idx_x : '0);

    assign desc_addr = base + AW'({units, 3'b000});
endmodule

// File: rtl/dw_seq.sv
module dw_seq
    import dw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_req,
    input  logic            stamp_req,
    input  logic            stamp_ok,
    input  logic            mode_wide,
    output logic            start,
    output logic            fetch_go,
    output logic            mem_req,
    output logic            mem_we,
    output logic [OFFW-1:0] word_off,
    output logic            ts_second,
    output cap_sel_e        cap_sel,
    output logic            done
);
    walk_state_e state, state_nxt;
    logic        wide_q;
    logic        go_stamp;

    assign fetch_go = (state == ST_IDLE) && fetch_req;
    assign go_stamp = (state == ST_IDLE) && !fetch_req && stamp_req && stamp_ok;
    assign start    = fetch_go || go_stamp;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (fetch_go)      state_nxt = ST_RD_LO;
                else if (go_stamp) state_nxt = ST_WR_TS1;
            end
            ST_RD_LO:  state_nxt = ST_RD_CTL;
            ST_RD_CTL: state_nxt = wide_q ? ST_RD_HI : ST_RD_END;
            ST_RD_HI:  state_nxt = ST_RD_END;
            ST_RD_END: state_nxt = ST_IDLE;
            ST_WR_TS1: state_nxt = ST_WR_TS2;
            ST_WR_TS2: state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        word_off  = '0;
        ts_second = 1'b0;
        unique case (state)
            ST_RD_LO:  begin mem_req = 1'b1; word_off = 5'd0; end
            ST_RD_CTL: begin mem_req = 1'b1; word_off = 5'd4; end
            ST_RD_HI:  begin mem_req = 1'b1; word_off = 5'd8; end
            ST_WR_TS1: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                word_off = wide_q ? 5'd16 : 5'd8;
            end
            ST_WR_TS2: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                ts_second = 1'b1;
                word_off  = wide_q ? 5'd20 : 5'd12;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q  <= 1'b0;
            cap_sel <= CAP_NONE;
            done    <= 1'b0;
        end else begin
            if (start) wide_q <= mode_wide;
            unique case (state)
                ST_RD_LO:  cap_sel <= CAP_LO;
                ST_RD_CTL: cap_sel <= CAP_CTL;
                ST_RD_HI:  cap_sel <= CAP_HI;
                default:   cap_sel <= CAP_NONE;
            endcase
            done <= (state == ST_RD_END) || (state == ST_WR_TS2);
        end
    end
endmodule

// File: rtl/dscr_walker.sv
module dscr_walker
    import dw_pkg::*;
#(
    parameter int AW   = 32,
    parameter int IDXW = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ring_base,
    input  logic [31:0]     dma_cfg,
    input  logic            ring_tx,
    input  logic [IDXW-1:0] desc_idx,
    input  logic            fetch_req,
    input  logic            stamp_req,
    input  logic [31:0]     stamp_w1,
    input  logic [31:0]     stamp_w2,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    output logic [63:0]     buf_addr,
    output logic [31:0]     buf_ctrl,
    output logic            done
);
    logic            wide, ext;
    logic [AW-1:0]   desc_addr;
    logic            start, fetch_go, ts_second;
    logic [OFFW-1:0] word_off;
    cap_sel_e        cap_sel;

    logic [AW-1:0]   desc_q;
    logic [31:0]     ts1_q, ts2_q;
    logic [31:0]     lo_q, hi_q, ctrl_q;

    dw_geom #(.AW(AW), .IDXW(IDXW)) geom_i (
        .base      (ring_base),
        .cfg       (dma_cfg),
        .ring_tx   (ring_tx),
        .idx       (desc_idx),
        .wide      (wide),
        .ext       (ext),
        .desc_addr (desc_addr)
    );

    dw_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_req (fetch_req),
        .stamp_req (stamp_req),
        .stamp_ok  (ext),
        .mode_wide (wide),
        .start     (start),
        .fetch_go  (fetch_go),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .word_off  (word_off),
        .ts_second (ts_second),
        .cap_sel   (cap_sel),
        .done      (done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q <= '0;
            ts1_q  <= '0;
            ts2_q  <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            ctrl_q <= '0;
        end else begin
            if (start) begin
                desc_q <= desc_addr;
                ts1_q  <= stamp_w1;
                ts2_q  <= stamp_w2;
            end
            if (fetch_go) hi_q <= '0;
            unique case (cap_sel)
                CAP_LO:  lo_q   <= mem_rdata;
                CAP_CTL: ctrl_q <= mem_rdata;
                CAP_HI:  hi_q   <= mem_rdata;
                default: ;
            endcase
        end
    end

    assign mem_addr  = desc_q + AW'(word_off);
    assign mem_wdata = ts_second ? ts2_q : ts1_q;
    assign buf_addr  = {hi_q, lo_q};
    assign buf_ctrl  = ctrl_q;
endmodule

// File: rtl/dscr_walker_chk.sv
module dscr_walker_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          done
);
    // R5: strobe lasts one cycle
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: no access in flight when done shows
    assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R3: back-to-back reads climb one word
    assert_read_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && $past(mem_req && !mem_we))
        |-> (mem_addr == $past(mem_addr) + AW'(4)));

    // R6: second stamp word follows the first
    assert_ts_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + AW'(4)));

    // R6: done right after the second write
    assert_ts_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |=> done);

    // R10: writes are requests
    assert_we_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);
endmodule

bind dscr_walker dscr_walker_chk #(.AW(AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .done     (done)
);

// File: tb/dscr_walker_tb_top.sv
`timescale 1ns/1ps
module dscr_walker_tb_top;
    localparam int AW   = 32;
    localparam int IDXW = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   ring_base = '0;
    logic [31:0]     dma_cfg = '0;
    logic            ring_tx = 1'b0;
    logic [IDXW-1:0] desc_idx = '0;
    logic            fetch_req = 1'b0;
    logic            stamp_req = 1'b0;
    logic [31:0]     stamp_w1 = '0;
    logic [31:0]     stamp_w2 = '0;
    logic            mem_req, mem_we;
    logic [AW-1:0]   mem_addr;
    logic [31:0]     mem_wdata;
    logic [31:0]     mem_rdata;
    logic [63:0]     buf_addr;
    logic [31:0]     buf_ctrl;
    logic            done;

    always #2 clk = ~clk;

    dscr_walker #(.AW(AW), .IDXW(IDXW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .dma_cfg(dma_cfg),
        .ring_tx(ring_tx), .desc_idx(desc_idx), .fetch_req(fetch_req),
        .stamp_req(stamp_req), .stamp_w1(stamp_w1), .stamp_w2(stamp_w2),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .buf_addr(buf_addr),
        .buf_ctrl(buf_ctrl), .done(done)
    );

    // word memory model, 1 KiB, read data one cycle after the request
    logic [31:0] mem [256];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < 256; w++) mem[w] <= 32'hD000_0000 | 32'(w << 2);
        end else begin
            if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr[9:2]];
    end

    // access log, sampled away from the active edge
    logic [31:0] rd_log [8];
    logic [31:0] wr_log [8];
    int rd_n, wr_n;
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (mem_we) begin
                if (wr_n < 8) wr_log[wr_n] = mem_addr;
                wr_n++;
            end else begin
                if (rd_n < 8) rd_log[rd_n] = mem_addr;
                rd_n++;
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // vector: wide, rx_ext, tx_ext, tx, idx[3:0], base[11:0]
    localparam logic [19:0] VECS [8] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 12'h000},
        {1'b0, 1'b1, 1'b0, 1'b0, 4'd2, 12'h080},
        {1'b0, 1'b1, 1'b0, 1'b1, 4'd4, 12'h100},
        {1'b0, 1'b0, 1'b1, 1'b1, 4'd1, 12'h180},
        {1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 12'h200},
        {1'b1, 1'b1, 1'b1, 1'b0, 4'd3, 12'h280},
        {1'b1, 1'b0, 1'b1, 1'b1, 4'd4, 12'h300},
        {1'b1, 1'b1, 1'b0, 1'b1, 4'd1, 12'h380}
    };

    function automatic logic [31:0] cfg_of(input bit wide, input bit rxe, input bit txe);
        return (32'(wide) << 30) | (32'(txe) << 29) | (32'(rxe) << 28);
    endfunction

    function automatic logic [31:0] mw(input logic [31:0] a);
        return mem[a[9:2]];
    endfunction

    int  lat;
    bit  done_after;

    task automatic clear_log();
        rd_n = 0;
        wr_n = 0;
    endtask

    task automatic wait_done();
        lat = 0;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (done) begin
                lat = k;
                break;
            end
        end
        @(negedge clk);
        done_after = done;
    endtask

    task automatic run_fetch(input logic [IDXW-1:0] idx);
        @(negedge clk);
        clear_log();
        desc_idx  = idx;
        fetch_req = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0;
        wait_done();
    endtask

    task automatic run_stamp(input logic [IDXW-1:0] idx, input logic [31:0] t1,
                             input logic [31:0] t2);
        @(negedge clk);
        clear_log();
        desc_idx  = idx;
        stamp_w1  = t1;
        stamp_w2  = t2;
        stamp_req = 1'b1;
        @(negedge clk);
        stamp_req = 1'b0;
        wait_done();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!done && !mem_req, "R1 idle outputs", {62'd0, done, mem_req}, 64'd0);
        check(buf_addr == 64'd0 && buf_ctrl == 32'd0, "R1 cleared data",
              {buf_addr[31:0], buf_ctrl}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < 8; v++) begin
            bit wide, rxe, txe, tx, ext;
            int k;
            logic [31:0] desc, tso, exp_hi;
            wide = VECS[v][19];
            rxe  = VECS[v][18];
            txe  = VECS[v][17];
            tx   = VECS[v][16];
            ext  = tx ? txe : rxe;
            k    = 1 + int'(wide) + int'(ext);
            desc = 32'(VECS[v][11:0]) + 32'(8 * int'(VECS[v][15:12]) * k);
            tso  = wide ? 32'd16 : 32'd8;
            dma_cfg   = cfg_of(wide, rxe, txe);
            ring_tx   = tx;
            ring_base = 32'(VECS[v][11:0]);

            run_fetch(IDXW'(VECS[v][15:12]));
            check(rd_log[0] == desc, "R2 entry address", 64'(rd_log[0]), 64'(desc));
            check(rd_n == (wide ? 3 : 2), "R3 read count", 64'(rd_n), 64'(wide ? 3 : 2));
            check(rd_log[1] == desc + 4, "R3 ctrl address", 64'(rd_log[1]), 64'(desc + 4));
            if (wide)
                check(rd_log[2] == desc + 8, "R3 upper address", 64'(rd_log[2]),
                      64'(desc + 8));
            exp_hi = wide ? mw(desc + 8) : 32'd0;
            check(buf_addr == {exp_hi, mw(desc)}, "R4 buffer address", buf_addr,
                  {exp_hi, mw(desc)});
            check(buf_ctrl == mw(desc + 4), "R3 control word", 64'(buf_ctrl),
                  64'(mw(desc + 4)));
            check(lat == (wide ? 4 : 3) && !done_after, "R5 done timing",
                  64'(lat), 64'(wide ? 4 : 3));
            check(wr_n == 0, "R10 no write in fetch", 64'(wr_n), 64'd0);

            run_stamp(IDXW'(VECS[v][15:12]), 32'h7500_0000 | 32'(v),
                      32'h7600_0000 | 32'(v));
            if (ext) begin
                check(wr_n == 2 && rd_n == 0, "R6 write count", 64'(wr_n), 64'd2);
                check(wr_log[0] == desc + tso, "R6 first stamp address",
                      64'(wr_log[0]), 64'(desc + tso));
                check(wr_log[1] == desc + tso + 4, "R6 second stamp address",
                      64'(wr_log[1]), 64'(desc + tso + 4));
                check(mw(desc + tso) == (32'h7500_0000 | 32'(v)), "R6 first stamp data",
                      64'(mw(desc + tso)), 64'(32'h7500_0000 | 32'(v)));
                check(mw(desc + tso + 4) == (32'h7600_0000 | 32'(v)),
                      "R6 second stamp data", 64'(mw(desc + tso + 4)),
                      64'(32'h7600_0000 | 32'(v)));
                check(lat == 2 && !done_after, "R6 done timing", 64'(lat), 64'd2);
            end else begin
                check(wr_n == 0 && rd_n == 0, "R7 no access", 64'(wr_n + rd_n), 64'd0);
                check(lat == 0, "R7 no done", 64'(lat), 64'd0);
            end
        end

        // R2: high index, both modes, arithmetic width
        dma_cfg   = cfg_of(1'b1, 1'b1, 1'b0);
        ring_tx   = 1'b0;
        ring_base = 32'h1000_0000;
        run_fetch(IDXW'(1023));
        check(rd_log[0] == 32'h1000_5FE8, "R2 high index", 64'(rd_log[0]),
              64'(32'h1000_5FE8));

        // R8: requests during a walk are ignored
        dma_cfg   = cfg_of(1'b1, 1'b1, 1'b1);
        ring_base = 32'h280;
        @(negedge clk);
        clear_log();
        desc_idx  = 10'd1;
        fetch_req = 1'b1;
        @(negedge clk);
        desc_idx  = 10'd2;
        stamp_req = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0;
        stamp_req = 1'b0;
        repeat (8) @(negedge clk);
        check(rd_n == 3 && wr_n == 0, "R8 single walk", 64'(rd_n * 16 + wr_n), 64'd48);
        check(rd_log[0] == 32'h298, "R8 first index kept", 64'(rd_log[0]), 64'h298);
        check(buf_addr == {mw(32'h2A0), mw(32'h298)}, "R8 data of first index",
              buf_addr, {mw(32'h2A0), mw(32'h298)});

        // R9: coincident requests, fetch wins
        dma_cfg   = cfg_of(1'b0, 1'b1, 1'b0);
        ring_base = 32'h080;
        @(negedge clk);
        clear_log();
        desc_idx  = 10'd0;
        fetch_req = 1'b1;
        stamp_req = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0;
        stamp_req = 1'b0;
        repeat (8) @(negedge clk);
        check(rd_n == 2 && wr_n == 0, "R9 fetch only", 64'(rd_n * 16 + wr_n), 64'd32);
        check(rd_log[0] == 32'h080, "R9 index zero", 64'(rd_log[0]), 64'h080);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule